// File: doc/BRIEF.md
# DS1 Transmit Channel Conditioner

This block conditions each outgoing 8-bit DS0 octet of a 24-channel DS1 frame before serialisation. Every octet passes through the same chain. The first stage applies a zero-code policy, which can be none, a substitution flag for a downstream line coder, or forcing one bit high. Next, signalling bits are placed in the least significant bit on signalling frames. Last, the bit that carries the remote alarm is cleared. The result is registered, so it appears one clock after the octet is offered.

The same block also produces the facility data link bit for each link slot. In normal operation it forwards an externally supplied bit. When the extended-superframe alarm is active, it sends a fixed sixteen-slot pattern instead. The caller provides the channel index, the frame number within the superframe, and a table of signalling nibbles for all channels. The block picks the nibble for the current channel.

Bits are numbered 1 to 8, with bit 1 the MSB and first on the line. In the vector, bit n sits at index 8-n. So bit 8 is index 0, bit 7 is index 1 and bit 2 is index 6.

Top module: `t1_tx_chan_cond`

## Requirements
- R1: An octet presented with `oct_vld` high in one cycle appears on `oct_out`, with `oct_vld_out` high, after the next rising edge. `oct_vld_out` is low in every other cycle.
- R2: When `zcs_off` is 1, the zero-code stage leaves the octet unchanged and `b8zs_req` stays 0, whatever the value of `b8zs_en`.
- R3: When `zcs_off`=0 and `b8zs_en`=0, an all-zero incoming octet has bit 7 (index 1, value 0x02) forced to 1. The check uses the octet before signalling insertion.
- R4: When `zcs_off`=0 and `b8zs_en`=1, the zero-code stage passes the octet unchanged. `b8zs_req` is 1 exactly when the final output octet is 0x00.
- R5: When `esf_mode`=1 and `rb_off`=0, frames 6, 12, 18 and 24 put signalling bit A, B, C and D respectively in bit 8 (index 0). The nibble for channel c is `sig_tbl[4c+3:4c]`, with bit 3 = A, bit 2 = B, bit 1 = C and bit 0 = D.
- R6: When `esf_mode`=0, only frames 6 and 12 carry signalling (A and B). All other frame numbers leave bit 8 unchanged.
- R7: When `rb_off`=1, bit 8 is never changed, on any frame.
- R8: When `yel_alm`=1, bit 2 (index 6, value 0x40) of every output octet is 0. This is applied after all other changes.
- R9: When the link alarm pattern is inactive, each `fdl_stb` loads `fdl_ext` into `fdl_bit` at the next edge. Between strobes, `fdl_bit` holds its value.
- R10: When `esf_mode`=1 and `esf_yel`=1, successive strobes produce eight 1s followed by eight 0s, repeating. When `esf_mode`=0, the pattern is inactive.
- R11: Each time the pattern goes from inactive to active, it restarts at the first 1.
- R12: After reset, `oct_out`=0x00, `oct_vld_out`=0, `b8zs_req`=0 and `fdl_bit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oct_vld | input | 1 | Octet offered this cycle |
| oct_in | input | 8 | Channel octet, index 7 = bit 1 |
| chan_idx | input | 5 | Channel number 0..23 |
| frame_num | input | 5 | Frame number within superframe, 1-based |
| sig_tbl | input | 96 | Signalling nibbles, 4 per channel |
| zcs_off | input | 1 | Transparent mode: no zero-code handling |
| b8zs_en | input | 1 | Substitution-flag mode select |
| rb_off | input | 1 | Disable signalling insertion |
| yel_alm | input | 1 | Force bit 2 low |
| esf_mode | input | 1 | 24-frame superframe when 1, 12-frame when 0 |
| esf_yel | input | 1 | Send link alarm pattern |
| fdl_ext | input | 1 | External link data bit |
| fdl_stb | input | 1 | Link bit slot strobe |
| oct_out | output | 8 | Conditioned octet |
| oct_vld_out | output | 1 | Conditioned octet valid |
| b8zs_req | output | 1 | Substitution request for this octet |
| fdl_bit | output | 1 | Link bit for the current slot |

## Verification
The octet path has only one state element, the output register. A wrong mode decode or a wrong bit position therefore shows up as a wrong value on the very next valid octet. The link pattern counter is the only state that lasts longer. A counter that is stuck, skips or fails to restart shows up within at most sixteen strobes, as a 1/0 run whose length or phase is wrong. Random octets are biased toward zero values and signalling frames, so that the stage ordering is exercised under every mode combination.

// File: rtl/t1_cond_pkg.sv
package t1_cond_pkg;

   typedef enum logic [1:0] {
      ZCS_NONE = 2'd0,
      ZCS_SUBST = 2'd1,
      ZCS_JAM = 2'd2
   } zcs_mode_e;

   // transparent overrides the substitution select
   function automatic zcs_mode_e zcs_decode(input logic off, input logic subst);
      if (off) return ZCS_NONE;
      if (subst) return ZCS_SUBST;
      return ZCS_JAM;
   endfunction

   // line bit n (1 = MSB, sent first) to vector index
   function automatic int unsigned line_bit_idx(input int unsigned n, input int unsigned w);
      return w - n;
   endfunction

endpackage

// File: rtl/t1_zcs_stage.sv
module t1_zcs_stage
   import t1_cond_pkg::*;
#(
   parameter int unsigned OCT_W = 8,
   parameter int unsigned JAM_LINE_BIT = 7
) (
   input  logic [OCT_W-1:0] oct_i,
   input  zcs_mode_e        mode_i,
   output logic [OCT_W-1:0] oct_o
);
   localparam int unsigned JAM_IDX = line_bit_idx(JAM_LINE_BIT, OCT_W);

   if (JAM_LINE_BIT < 1 || JAM_LINE_BIT > OCT_W) begin : g_bad_jam
      $error("JAM_LINE_BIT out of range");
   end

   logic is_zero;
   assign is_zero = (oct_i == '0);

   always_comb begin
      oct_o = oct_i;
      if (mode_i == ZCS_JAM && is_zero) begin
         oct_o[JAM_IDX] = 1'b1;
      end
   end

endmodule

// File: rtl/t1_rbs_stage.sv
module t1_rbs_stage
   import t1_cond_pkg::*;
#(
   parameter int unsigned OCT_W = 8,
   parameter int unsigned NUM_CH = 24,
   parameter int unsigned SIG_W = 4,
   parameter int unsigned FRM_W = 5,
   parameter int unsigned RB_PERIOD = 6,
   parameter int unsigned ESF_FRAMES = 24,
   parameter int unsigned SF_FRAMES = 12,
   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [OCT_W-1:0]        oct_i,
   input  logic [CH_W-1:0]         chan_i,
   input  logic [FRM_W-1:0]        frame_i,
   input  logic [NUM_CH*SIG_W-1:0] sig_tbl_i,
   input  logic                    rb_off_i,
   input  logic                    esf_i,
   output logic [OCT_W-1:0]        oct_o
);
   localparam int unsigned RB_IDX = line_bit_idx(8, OCT_W);
   localparam int unsigned TBL_N = 2 ** CH_W;
   localparam logic [FRM_W-1:0] PER = FRM_W'(RB_PERIOD);
   localparam logic [FRM_W-1:0] ESF_MAX = FRM_W'(ESF_FRAMES);
   localparam logic [FRM_W-1:0] SF_MAX = FRM_W'(SF_FRAMES);

   if (OCT_W < 8) begin : g_bad_w
      $error("OCT_W must be at least 8");
   end
   if (ESF_FRAMES / RB_PERIOD > SIG_W) begin : g_bad_sig
      $error("not enough signalling bits for the superframe");
   end
   if (ESF_FRAMES >= 2 ** FRM_W) begin : g_bad_frm
      $error("FRM_W too narrow");
   end

   logic [SIG_W-1:0] nib_tbl [TBL_N];

   for (genvar c = 0; c < TBL_N; c++) begin : g_nib
      if (c < NUM_CH) begin : g_real
         assign nib_tbl[c] = sig_tbl_i[c*SIG_W +: SIG_W];
      end else begin : g_pad
         assign nib_tbl[c] = '0;
      end
   end

   logic [SIG_W-1:0] nib;
   logic [FRM_W-1:0] slot;
   logic [FRM_W-1:0] frm_max;
   logic             on_slot;
   logic             sig_bit;

   assign nib     = nib_tbl[chan_i];
   assign slot    = frame_i / PER;
   assign frm_max = esf_i ? ESF_MAX : SF_MAX;
   assign on_slot = !rb_off_i && (frame_i % PER == '0) && (slot != '0)
                    && (frame_i <= frm_max);

   always_comb begin
      sig_bit = 1'b0;
      for (int k = 1; k <= int'(SIG_W); k++) begin
         if (int'(slot) == k) sig_bit = nib[SIG_W - k];
      end
   end

   always_comb begin
      oct_o = oct_i;
      if (on_slot) oct_o[RB_IDX] = sig_bit;
   end

endmodule

// File: rtl/t1_fdl_gen.sv
module t1_fdl_gen #(
   parameter int unsigned HALF = 8,
   localparam int unsigned CNT_W = $clog2(2 * HALF)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pat_on_i,
   input  logic stb_i,
   input  logic ext_i,
   output logic bit_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * HALF - 1);
   localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF);

   if (HALF < 1) begin : g_bad_half
      $error("HALF must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             pat_bit;

   assign pat_bit = (cnt_q < HALF_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!pat_on_i) begin
         cnt_q <= '0;
      end else if (stb_i) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_o <= 1'b0;
      end else if (stb_i) begin
         bit_o <= pat_on_i ? pat_bit : ext_i;
      end
   end

endmodule

// File: rtl/t1_tx_chan_cond.sv
module t1_tx_chan_cond
   import t1_cond_pkg::*;
#(
   parameter int unsigned OCT_W = 8,
   parameter int unsigned NUM_CH = 24,
   parameter int unsigned SIG_W = 4,
   parameter int unsigned FRM_W = 5,
   parameter int unsigned RB_PERIOD = 6,
   parameter int unsigned ESF_FRAMES = 24,
   parameter int unsigned SF_FRAMES = 12,
   parameter int unsigned FDL_HALF = 8,
   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    oct_vld,
   input  logic [OCT_W-1:0]        oct_in,
   input  logic [CH_W-1:0]         chan_idx,
   input  logic [FRM_W-1:0]        frame_num,
   input  logic [NUM_CH*SIG_W-1:0] sig_tbl,
   input  logic                    zcs_off,
   input  logic                    b8zs_en,
   input  logic                    rb_off,
   input  logic                    yel_alm,
   input  logic                    esf_mode,
   input  logic                    esf_yel,
   input  logic                    fdl_ext,
   input  logic                    fdl_stb,
   output logic [OCT_W-1:0]        oct_out,
   output logic                    oct_vld_out,
   output logic                    b8zs_req,
   output logic                    fdl_bit
);
   localparam int unsigned YEL_IDX = line_bit_idx(2, OCT_W);

   zcs_mode_e        mode;
   logic [OCT_W-1:0] zcs_oct;
   logic [OCT_W-1:0] rbs_oct;
   logic [OCT_W-1:0] fin_oct;

   assign mode = zcs_decode(zcs_off, b8zs_en);

   t1_zcs_stage #(
      .OCT_W(OCT_W),
      .JAM_LINE_BIT(7)
   ) u_zcs (
      .oct_i (oct_in),
      .mode_i(mode),
      .oct_o (zcs_oct)
   );

   t1_rbs_stage #(
      .OCT_W     (OCT_W),
      .NUM_CH    (NUM_CH),
      .SIG_W     (SIG_W),
      .FRM_W     (FRM_W),
      .RB_PERIOD (RB_PERIOD),
      .ESF_FRAMES(ESF_FRAMES),
      .SF_FRAMES (SF_FRAMES)
   ) u_rbs (
      .oct_i    (zcs_oct),
      .chan_i   (chan_idx),
      .frame_i  (frame_num),
      .sig_tbl_i(sig_tbl),
      .rb_off_i (rb_off),
      .esf_i    (esf_mode),
      .oct_o    (rbs_oct)
   );

   always_comb begin
      fin_oct = rbs_oct;
      if (yel_alm) fin_oct[YEL_IDX] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oct_out     <= '0;
         oct_vld_out <= 1'b0;
         b8zs_req    <= 1'b0;
      end else begin
         oct_vld_out <= oct_vld;
         if (oct_vld) begin
            oct_out  <= fin_oct;
            b8zs_req <= (mode == ZCS_SUBST) && (fin_oct == '0);
         end
      end
   end

   t1_fdl_gen #(
      .HALF(FDL_HALF)
   ) u_fdl (
      .clk     (clk),
      .rst_n   (rst_n),
      .pat_on_i(esf_mode && esf_yel),
      .stb_i   (fdl_stb),
      .ext_i   (fdl_ext),
      .bit_o   (fdl_bit)
   );

endmodule

// File: rtl/t1_tx_chan_cond_chk.sv
module t1_tx_chan_cond_chk #(
   parameter int unsigned OCT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             oct_vld,
   input logic [OCT_W-1:0] oct_in,
   input logic             zcs_off,
   input logic             b8zs_en,
   input logic             rb_off,
   input logic             yel_alm,
   input logic             esf_mode,
   input logic             esf_yel,
   input logic             fdl_ext,
   input logic             fdl_stb,
   input logic [OCT_W-1:0] oct_out,
   input logic             oct_vld_out,
   input logic             b8zs_req,
   input logic             fdl_bit
);
   localparam int unsigned I_B2 = OCT_W - 2;
   localparam int unsigned I_B7 = OCT_W - 7;
   localparam int unsigned I_B8 = OCT_W - 8;

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      oct_vld |=> oct_vld_out); // R1
   AST_VLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !oct_vld |=> !oct_vld_out); // R1
   AST_NO_REQ_OUTSIDE_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_vld && (zcs_off || !b8zs_en)) |=> !b8zs_req); // R2
   AST_JAM_SETS_B7: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_vld && oct_in == '0 && !zcs_off && !b8zs_en) |=> oct_out[I_B7]); // R3
   AST_REQ_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      b8zs_req |-> (oct_out == '0)); // R4
   AST_RB_OFF_KEEPS_B8: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_vld && rb_off) |=> (oct_out[I_B8] == $past(oct_in[I_B8]))); // R7
   AST_YEL_CLEARS_B2: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_vld && yel_alm) |=> !oct_out[I_B2]); // R8
   AST_FDL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (fdl_stb && !(esf_mode && esf_yel)) |=> (fdl_bit == $past(fdl_ext))); // R9
   AST_FDL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fdl_stb |=> $stable(fdl_bit)); // R9
   AST_FDL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (fdl_stb && esf_mode && esf_yel && !$past(esf_mode && esf_yel)) |=> fdl_bit); // R11

endmodule

bind t1_tx_chan_cond t1_tx_chan_cond_chk #(.OCT_W(OCT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .oct_vld    (oct_vld),
   .oct_in     (oct_in),
   .zcs_off    (zcs_off),
   .b8zs_en    (b8zs_en),
   .rb_off     (rb_off),
   .yel_alm    (yel_alm),
   .esf_mode   (esf_mode),
   .esf_yel    (esf_yel),
   .fdl_ext    (fdl_ext),
   .fdl_stb    (fdl_stb),
   .oct_out    (oct_out),
   .oct_vld_out(oct_vld_out),
   .b8zs_req   (b8zs_req),
   .fdl_bit    (fdl_bit)
);

// File: tb/t1_tx_chan_cond_tb.sv
module t1_tx_chan_cond_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        oct_vld = 1'b0;
   logic [7:0]  oct_in = '0;
   logic [4:0]  chan_idx = '0;
   logic [4:0]  frame_num = 5'd1;
   logic [95:0] sig_tbl = '0;
   logic        zcs_off = 1'b0, b8zs_en = 1'b0, rb_off = 1'b0, yel_alm = 1'b0;
   logic        esf_mode = 1'b1, esf_yel = 1'b0, fdl_ext = 1'b0, fdl_stb = 1'b0;
   logic [7:0]  oct_out;
   logic        oct_vld_out, b8zs_req, fdl_bit;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   t1_tx_chan_cond dut_i (
      .clk(clk), .rst_n(rst_n), .oct_vld(oct_vld), .oct_in(oct_in),
      .chan_idx(chan_idx), .frame_num(frame_num), .sig_tbl(sig_tbl),
      .zcs_off(zcs_off), .b8zs_en(b8zs_en), .rb_off(rb_off), .yel_alm(yel_alm),
      .esf_mode(esf_mode), .esf_yel(esf_yel), .fdl_ext(fdl_ext), .fdl_stb(fdl_stb),
      .oct_out(oct_out), .oct_vld_out(oct_vld_out), .b8zs_req(b8zs_req),
      .fdl_bit(fdl_bit)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // expected {req, octet} from the requirements
   function automatic logic [8:0] expect_oct(input logic [7:0] o, input logic [3:0] nib,
         input int fr, input logic zo, input logic b8, input logic rbo,
         input logic yel, input logic esf);
      logic [7:0] r = o;
      logic       q;
      int         lim = esf ? 24 : 12;
      if (!zo && !b8 && o == 8'h00) r = r | 8'h02;                  // R3
      if (!rbo && fr > 0 && fr % 6 == 0 && fr <= lim) r[0] = nib[3 - (fr/6 - 1)]; // R5 R6
      if (yel) r = r & 8'hBF;                                         // R8
      q = !zo && b8 && (r == 8'h00);                                   // R4
      return {q, r};
   endfunction

   task automatic send(input logic [7:0] o, input int ch, input int fr, input logic zo,
                       input logic b8, input logic rbo, input logic yel, input logic esf,
                       input string tag);
      logic [8:0] e;
      @(negedge clk);
      oct_in = o; chan_idx = 5'(ch); frame_num = 5'(fr);
      zcs_off = zo; b8zs_en = b8; rb_off = rbo; yel_alm = yel; esf_mode = esf;
      oct_vld = 1'b1;
      e = expect_oct(o, sig_tbl[ch*4 +: 4], fr, zo, b8, rbo, yel, esf);
      @(negedge clk);
      oct_vld = 1'b0;
      check(oct_vld_out === 1'b1, {tag, " R1 valid"}, 32'(oct_vld_out), 1);
      check(oct_out === e[7:0], {tag, " octet"}, 32'(oct_out), 32'(e[7:0]));
      check(b8zs_req === e[8], {tag, " R4 req"}, 32'(b8zs_req), 32'(e[8]));
   endtask

   task automatic fdl_pulse(input logic ext, input logic exp, input string tag);
      @(negedge clk);
      fdl_ext = ext; fdl_stb = 1'b1;
      @(negedge clk);
      fdl_stb = 1'b0;
      check(fdl_bit === exp, tag, 32'(fdl_bit), 32'(exp));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5EED_0D51));
      repeat (3) @(negedge clk);
      // R12 reset state
      check(oct_out === 8'h00, "R12 oct_out", 32'(oct_out), 0);
      check(oct_vld_out === 1'b0, "R12 vld", 32'(oct_vld_out), 0);
      check(b8zs_req === 1'b0, "R12 req", 32'(b8zs_req), 0);
      check(fdl_bit === 1'b0, "R12 fdl", 32'(fdl_bit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(oct_vld_out === 1'b0, "R1 idle", 32'(oct_vld_out), 0);

      sig_tbl = '0;
      sig_tbl[5*4 +: 4] = 4'b1010;
      // directed corners
      send(8'h00, 0, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3 jam");
      send(8'h00, 0, 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R2 transparent");
      send(8'h00, 0, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4 subst zero");
      send(8'h40, 0, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 R8 zero after alarm");
      send(8'h55, 0, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4 nonzero");
      send(8'hFF, 5, 6,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 A");
      send(8'hFE, 5, 12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 B");
      send(8'hFF, 5, 18, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 C");
      send(8'hFE, 5, 24, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 D");
      send(8'hFE, 5, 12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 B");
      send(8'hFE, 5, 18, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 no slot");
      send(8'hFE, 5, 6,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7 off");
      send(8'h00, 5, 6,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 R5 R8 order");
      send(8'hFF, 3, 7,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 alarm");

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] o;
         logic       esf;
         int         fr;
         sig_tbl = {$urandom(), $urandom(), $urandom()};
         o = ($urandom_range(0, 9) < 3) ? 8'h00 : 8'($urandom());
         if ($urandom_range(0, 3) == 0) o = 8'h40;
         esf = 1'($urandom());
         fr = ($urandom_range(0, 1) == 0) ? 6 * $urandom_range(1, 4)
                                          : $urandom_range(1, 24);
         if (!esf && fr > 12) fr = fr - 12;
         send(o, $urandom_range(0, 23), fr, 1'($urandom_range(0, 3) == 0),
              1'($urandom()), 1'($urandom_range(0, 3) == 0), 1'($urandom()), esf,
              "R2 R3 R4 R5 R6 R7 R8 rnd");
      end

      // link bit tests
      esf_mode = 1'b1; esf_yel = 1'b0;
      for (int n = 0; n < 8; n++) begin
         logic b = 1'($urandom());
         fdl_pulse(b, b, "R9 pass");
      end
      fdl_pulse(1'b1, 1'b1, "R9 pass");
      @(negedge clk); fdl_ext = 1'b0;
      @(negedge clk);
      check(fdl_bit === 1'b1, "R9 hold", 32'(fdl_bit), 1);
      esf_yel = 1'b1;
      for (int n = 0; n < 40; n++) fdl_pulse(1'($urandom()), 1'((n % 16) < 8), "R10 pattern");
      esf_yel = 1'b0;
      fdl_pulse(1'b0, 1'b0, "R9 after alarm");
      esf_yel = 1'b1;
      for (int n = 0; n < 11; n++) fdl_pulse(1'b0, 1'((n % 16) < 8), "R10 pattern");
      esf_yel = 1'b0;
      @(negedge clk);
      esf_yel = 1'b1;
      for (int n = 0; n < 10; n++) fdl_pulse(1'b0, 1'(n < 8), "R11 restart");
      esf_mode = 1'b0;
      fdl_pulse(1'b1, 1'b1, "R10 gated by mode");
      fdl_pulse(1'b0, 1'b0, "R10 gated by mode");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule